// File: doc/BRIEF.md
# Frame-Aligned Controlled Slip Buffer

This block moves a channelized time-division stream from a write clock domain to a read clock domain. Each frame is 193 bits: a framing bit and then 24 channel octets. The write side takes one bit per write clock and uses a marker pulse on the framing bit to find frame alignment. The read side builds its own frame, one bit per read clock, with a framing bit that the block generates. The nominal line rate is 1.544 Mbit/s, which is one frame every 125 us.

The write and read clocks are never exactly equal, so the store between them slowly fills or drains. The block decides only when the read side reaches a frame boundary. At that point it either drops one whole incoming frame (overflow) or sends the previous frame again (underflow). Each channel therefore loses or repeats exactly one octet, and the channels never shift against each other. The write position crosses into the read domain as a Gray-coded count of eighth-frames. Two sticky flags and a saturating counter record the slips, and a clear pulse resets them.

Top module: `slip_buffer`

## Requirements
- R1: Each output frame is 193 read clocks long. `rd_fsync` is high for one cycle while `rd_data` carries the framing bit, and 192 payload bits follow: channel 1 octet first through channel 24, each octet most significant bit first, in the same bit order as on the write side.
- R2: The generated framing bit is 0 in the first output frame after reset and alternates 0, 1, 0, ... from one frame to the next.
- R3: The write side ignores all input until the first `wr_fsync` pulse. From then on it counts 193-bit frames freely, and a later `wr_fsync` pulse (including one in mid-frame) has no effect on the output.
- R4: After reset the outputs stay low. The first output frame starts only once the writer is one and a half frames ahead, and that first frame carries the first input frame.
- R5: With equal write and read rates, consecutive output frames carry consecutive input frames, and no slip is recorded.
- R6: When the writer is more than two and a half frames ahead at a read frame boundary, one whole input frame is skipped. `ovf_flag` is set and `slip_cnt` rises by one for each such slip.
- R7: When the writer is less than one full frame ahead at a read frame boundary, the previous frame is sent again. `udf_flag` is set and `slip_cnt` rises by one for each such slip.
- R8: Every output frame is one complete input frame: all 24 octets come from the same input frame, also across slips.
- R9: The flags are sticky and, together with `slip_cnt`, are cleared by a one-cycle `slip_clr` pulse. A slip in the same cycle as the clear is still recorded.
- R10: `slip_cnt` saturates at 2^CNT_W-1.
- R11: During and right after reset, `rd_data`, `rd_fsync`, both flags and `slip_cnt` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write bit clock |
| wr_rst_n | input | 1 | Write domain reset, active low |
| wr_data | input | 1 | Incoming serial bit |
| wr_fsync | input | 1 | High on the incoming framing bit |
| rd_clk | input | 1 | Read bit clock |
| rd_rst_n | input | 1 | Read domain reset, active low |
| slip_clr | input | 1 | Clears flags and counter (read domain) |
| rd_data | output | 1 | Outgoing serial bit |
| rd_fsync | output | 1 | High on the outgoing framing bit |
| ovf_flag | output | 1 | Sticky: a frame was skipped |
| udf_flag | output | 1 | Sticky: a frame was repeated |
| slip_cnt | output | CNT_W | Saturating count of slips |

## Verification
The hardest states to reach are the slip boundaries, because the fill can only be steered through the ratio of the two clock rates. The bench runs the write clock 5% or 10% faster or slower than the read clock for tens of frames, so the fill drifts across a threshold one or more times. Each incoming frame carries octets numbered from its frame index. The step between successive output frames therefore shows a normal frame, a skip or a repeat, and any octet that does not belong to the frame exposes a partial slip. A small counter width lets saturation appear within a short run.

// File: rtl/slip_buffer.sv
module slip_buffer #(
  parameter int CHANNELS = 24,
  parameter int CNT_W    = 8
) (
  input  logic             wr_clk,
  input  logic             wr_rst_n,
  input  logic             wr_data,
  input  logic             wr_fsync,
  input  logic             rd_clk,
  input  logic             rd_rst_n,
  input  logic             slip_clr,
  output logic             rd_data,
  output logic             rd_fsync,
  output logic             ovf_flag,
  output logic             udf_flag,
  output logic [CNT_W-1:0] slip_cnt
);
  localparam int PAY   = CHANNELS * 8;
  localparam int FLEN  = PAY + 1;
  localparam int TICK  = PAY / 8;
  localparam int DEPTH = 4 * PAY;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(FLEN);
  localparam int TW    = $clog2(TICK);
  localparam int PW    = 8;
  localparam logic [CW-1:0]    LAST    = CW'(PAY);
  localparam logic [TW-1:0]    TLAST   = TW'(TICK - 1);
  localparam logic [AW-1:0]    SLOT_SZ = AW'(PAY);
  localparam logic [PW-1:0]    LO_T    = 8;
  localparam logic [PW-1:0]    HI_T    = 20;
  localparam logic [PW-1:0]    START_T = 12;
  localparam logic [CNT_W-1:0] CMAX    = '1;

  logic mem [DEPTH];

  // write domain
  logic          wlock;
  logic [CW-1:0] wcnt;
  logic [TW-1:0] wsub;
  logic [PW-1:0] wpos, wgray;
  logic [AW-1:0] waddr;
  logic          wen;

  assign wen   = wlock && (wcnt != '0);
  assign waddr = AW'(wpos[4:3]) * SLOT_SZ + AW'(wcnt) - AW'(1);

  always_ff @(posedge wr_clk or negedge wr_rst_n)
    if (!wr_rst_n) begin
      wlock <= 1'b0;
      wcnt  <= '0;
      wsub  <= '0;
      wpos  <= '0;
      wgray <= '0;
    end else begin
      wgray <= wpos ^ (wpos >> 1);
      if (!wlock) begin
        if (wr_fsync) begin
          wlock <= 1'b1;
          wcnt  <= CW'(1);
        end
      end else begin
        wcnt <= (wcnt == LAST) ? '0 : wcnt + CW'(1);
        if (wcnt != '0) begin
          wsub <= (wsub == TLAST) ? '0 : wsub + TW'(1);
          if (wsub == TLAST) wpos <= wpos + PW'(1);
        end
      end
    end

  always_ff @(posedge wr_clk)
    if (wen) mem[waddr] <= wr_data;

  // read domain
  logic [PW-1:0]   s1, s2, wbin, fill;
  logic            started, fpar;
  logic [CW-1:0]   rc;
  logic [PW-4:0]   rframe, nframe;
  logic [1:0]      rslot, nslot;
  logic [AW-1:0]   raddr;
  logic            under, over, bnd, of_ev, uf_ev;

  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= wgray;
      s2 <= s1;
    end

  always_comb begin
    wbin[PW-1] = s2[PW-1];
    for (int i = PW - 2; i >= 0; i--) wbin[i] = wbin[i+1] ^ s2[i];
  end

  assign fill   = wbin - {rframe, 3'b000};
  assign under  = fill < LO_T;
  assign over   = fill > HI_T;
  assign nslot  = under ? rframe[1:0] - 2'd1 : over ? rframe[1:0] + 2'd1 : rframe[1:0];
  assign nframe = under ? rframe : over ? rframe + (PW-3)'(2) : rframe + (PW-3)'(1);
  assign bnd    = started && (rc == '0);
  assign of_ev  = bnd && over;
  assign uf_ev  = bnd && under;
  assign raddr  = AW'(rslot) * SLOT_SZ + AW'(rc) - AW'(1);

  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) begin
      started  <= 1'b0;
      rc       <= '0;
      rframe   <= '0;
      rslot    <= '0;
      fpar     <= 1'b0;
      rd_data  <= 1'b0;
      rd_fsync <= 1'b0;
    end else if (!started) begin
      if (fill >= START_T) started <= 1'b1;
    end else begin
      rc       <= (rc == LAST) ? '0 : rc + CW'(1);
      rd_fsync <= (rc == '0);
      if (rc == '0) begin
        rd_data <= fpar;
        fpar    <= ~fpar;
        rslot   <= nslot;
        rframe  <= nframe;
      end else begin
        rd_data <= mem[raddr];
      end
    end

  // R8
  slot_safe_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    bnd |-> nslot != wbin[4:3]);

  // R1
  fsync_gap_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_fsync |=> !rd_fsync);

  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) begin
      ovf_flag <= 1'b0;
      udf_flag <= 1'b0;
      slip_cnt <= '0;
    end else begin
      ovf_flag <= (ovf_flag & ~slip_clr) | of_ev;
      udf_flag <= (udf_flag & ~slip_clr) | uf_ev;
      if (slip_clr)
        slip_cnt <= (of_ev || uf_ev) ? CNT_W'(1) : '0;
      else if ((of_ev || uf_ev) && slip_cnt != CMAX)
        slip_cnt <= slip_cnt + CNT_W'(1);
    end

  // R9
  sticky_flag_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (ovf_flag && !slip_clr) |=> ovf_flag);

  // R10
  cnt_sat_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (slip_cnt == CMAX && !slip_clr) |=> slip_cnt == CMAX);

  // R6
  cnt_step_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !slip_clr |=> (slip_cnt == $past(slip_cnt) || slip_cnt == $past(slip_cnt) + CNT_W'(1)));
endmodule

// File: tb/slip_buffer_tb.sv
`timescale 1ns/1ps
module slip_buffer_tb_top;
  logic clk = 0, wclk = 0;
  logic rrst_n = 0, wrst_n = 0;
  logic wr_data = 0, wr_fsync = 0, clr = 0;
  logic rd_data, rd_fsync, ovf_flag, udf_flag;
  logic [1:0] slip_cnt;

  slip_buffer #(.CHANNELS(24), .CNT_W(2)) dut_i (
    .wr_clk(wclk), .wr_rst_n(wrst_n), .wr_data(wr_data), .wr_fsync(wr_fsync),
    .rd_clk(clk), .rd_rst_n(rrst_n), .slip_clr(clr),
    .rd_data(rd_data), .rd_fsync(rd_fsync),
    .ovf_flag(ovf_flag), .udf_flag(udf_flag), .slip_cnt(slip_cnt));

  real whalf = 5.0;
  always #5 clk = ~clk;
  initial begin
    #2;
    forever #(whalf) wclk = ~wclk;
  end

  int ntests = 0, nfail = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  // writer model
  bit wgo = 0, wsync_en = 0, spur = 0;
  int wbit = 0, wframe = 0, cyc_in = -1;
  always @(negedge wclk) begin
    if (!wgo) begin
      wr_data  = 1'b0;
      wr_fsync = 1'b0;
    end else if (!wsync_en) begin
      wr_data  = ~wr_data;
      wr_fsync = 1'b0;
    end else begin
      if (wbit == 0) begin
        wr_fsync = 1'b1;
        wr_data  = 1'b1;
        if (cyc_in < 0) cyc_in = cyc;
      end else begin
        logic [7:0] oct;
        oct = 8'(wframe * 24 + (wbit - 1) / 8);
        wr_data  = oct[7 - ((wbit - 1) % 8)];
        wr_fsync = spur && (wbit == 100);
        if (wbit == 100) spur = 0;
      end
      wbit++;
      if (wbit == 193) begin
        wbit = 0;
        wframe++;
      end
    end
  end

  // output monitor
  logic [191:0] sh;
  int nb = 0, nframes = 0, nnorm = 0, nskip = 0, nrep = 0, nbad = 0, nfbad = 0;
  int nfsync = 0, cyc_out = -1, first_o0 = -1, first_fb = -1;
  bit coll = 0, have_prev = 0;
  logic fb, prev_fb;
  logic [7:0] prev_o0;
  always @(negedge clk) begin
    if (rd_fsync) begin
      fb = rd_data;
      nb = 0;
      coll = 1;
      nfsync++;
      if (cyc_out < 0) cyc_out = cyc;
    end else if (coll) begin
      sh = {sh[190:0], rd_data};
      nb++;
      if (nb == 192) begin
        logic [7:0] o0, dl;
        coll = 0;
        o0 = sh[191 -: 8];
        for (int c = 1; c < 24; c++)
          if (sh[191 - 8*c -: 8] != 8'(o0 + c)) nbad++;
        if (have_prev) begin
          dl = o0 - prev_o0;
          if (dl == 8'd24) nnorm++;
          else if (dl == 8'd48) nskip++;
          else if (dl == 8'd0) nrep++;
          else nbad++;
          if (fb == prev_fb) nfbad++;
        end else begin
          first_o0 = int'(o0);
          first_fb = int'(fb);
        end
        prev_o0 = o0;
        prev_fb = fb;
        have_prev = 1;
        nframes++;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    ntests++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    nnorm = 0; nskip = 0; nrep = 0; nbad = 0; nfbad = 0; nframes = 0;
  endtask

  task automatic wait_frames(int n);
    repeat (n * 193) @(posedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R11 rd_fsync", int'(rd_fsync), 0);
    check("R11 rd_data", int'(rd_data), 0);
    check("R11 flags", int'({ovf_flag, udf_flag}), 0);
    check("R11 slip_cnt", int'(slip_cnt), 0);
  endtask

  task automatic t_unlocked();
    wgo = 1;
    repeat (600) @(posedge clk);
    check("R3 no output before wr_fsync", nfsync, 0);
    check("R4 outputs idle", int'(rd_data), 0);
  endtask

  task automatic t_start();
    @(posedge wclk);
    wbit = 0; wframe = 0; wsync_en = 1;
    wait_frames(25);
    check("R4 start latency in range", int'(cyc_out - cyc_in >= 288 && cyc_out - cyc_in <= 302), 1);
    check("R4 first frame is input frame 0", first_o0, 0);
    check("R2 first framing bit", first_fb, 0);
    check("R2 framing bit alternates", nfbad, 0);
    check("R1 R8 octet order and integrity", nbad, 0);
    check("R5 no slips at equal rates", nskip + nrep, 0);
    check("R5 consecutive frames", nnorm, nframes - 1);
    check("R5 flags clear", int'({ovf_flag, udf_flag, slip_cnt}), 0);
  endtask

  task automatic t_spurious();
    clear_stats();
    spur = 1;
    wait_frames(10);
    check("R3 mid-frame wr_fsync ignored", nskip + nrep + nbad, 0);
    check("R3 frames keep flowing", int'(nframes >= 9), 1);
  endtask

  task automatic t_overflow();
    clear_stats();
    whalf = 4.75;
    wait_frames(60);
    whalf = 5.0;
    wait_frames(2);
    check("R6 frame skipped", int'(nskip >= 1), 1);
    check("R6 no repeat", nrep, 0);
    check("R8 whole frames on skip", nbad, 0);
    check("R6 ovf_flag", int'(ovf_flag), 1);
    check("R6 udf_flag", int'(udf_flag), 0);
    check("R6 slip_cnt", int'(slip_cnt), (nskip > 3) ? 3 : nskip);
  endtask

  task automatic t_clear();
    pulse_clr();
    @(negedge clk);
    check("R9 flags cleared", int'({ovf_flag, udf_flag}), 0);
    check("R9 counter cleared", int'(slip_cnt), 0);
  endtask

  task automatic t_underflow();
    clear_stats();
    whalf = 5.25;
    wait_frames(60);
    whalf = 5.0;
    wait_frames(2);
    check("R7 frame repeated", int'(nrep >= 1), 1);
    check("R7 no skip", nskip, 0);
    check("R8 whole frames on repeat", nbad, 0);
    check("R7 udf_flag", int'(udf_flag), 1);
    check("R7 ovf_flag", int'(ovf_flag), 0);
    check("R7 slip_cnt", int'(slip_cnt), (nrep > 3) ? 3 : nrep);
    check("R2 framing bit alternates across slips", nfbad, 0);
  endtask

  task automatic t_saturate();
    pulse_clr();
    clear_stats();
    whalf = 4.5;
    wait_frames(60);
    whalf = 5.0;
    wait_frames(2);
    check("R10 enough slips", int'(nskip >= 4), 1);
    check("R10 counter saturated", int'(slip_cnt), 3);
    check("R8 integrity at 10% offset", nbad, 0);
  endtask

  bit done = 0;
  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    t_reset();
    rrst_n = 1; wrst_n = 1;
    t_reset();
    t_unlocked();
    t_start();
    t_spurious();
    t_overflow();
    t_clear();
    t_underflow();
    t_saturate();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      ntests++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end
endmodule